// File: doc/BRIEF.md
# Flag-Producing 16-bit Adder

This block adds two 16-bit operands and reports the sum together with five condition flags: zero, carry, digit carry, overflow and negative. Each accepted addition is captured on the clock edge where the input strobe is high. The sum appears on a registered output with a one-cycle valid pulse, and the five flags are merged into a 16-bit status register.

The merge is masked. An addition writes only the five flag positions, and every other status bit keeps its value. A separate load port writes the whole status word, which lets surrounding logic set the bits that the adder never touches. If a load and an addition arrive in the same cycle, the load is applied first and the five new flags then overwrite their own positions.

Top module: `flag_adder`

## Requirements
- R1: On the edge where `inValid` is high, `result` takes the low 16 bits of `opA + opB` and keeps that value until the next accepted addition.
- R2: `resValid` is high in exactly the cycle after each edge that accepts an addition, and low otherwise.
- R3: Carry, at status bit 0, is set by an addition when the 17-bit sum of the operands has bit 16 set, and cleared otherwise.
- R4: Zero, at status bit 1, is set by an addition when the 16-bit result is 0x0000, and cleared otherwise.
- R5: Overflow, at status bit 2, is set by an addition in two cases: both operands have bit 15 clear and the result has bit 15 set, or both operands have bit 15 set and the result has bit 15 clear. It is cleared otherwise.
- R6: Negative, at status bit 3, takes bit 15 of the result on each addition.
- R7: Digit carry, at status bit 8, takes bit 4 of `(opA ^ opB ^ result)` on each addition.
- R8: An addition leaves status bits 4 to 7 and 9 to 15 unchanged.
- R9: When neither `inValid` nor `stWrEn` is high, `status` and `result` hold their values.
- R10: When `stWrEn` is high, `status` takes `stWrData` on the edge. If `inValid` is high in the same cycle, bits 0 to 3 and bit 8 take the new flags instead, and the remaining bits take `stWrData`.
- R11: A synchronous active-high `rst` clears `status` and `result` to zero and holds `resValid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opA | input | 16 | First addend |
| opB | input | 16 | Second addend |
| inValid | input | 1 | Accepts an addition on this edge |
| stWrEn | input | 1 | Loads the status word on this edge |
| stWrData | input | 16 | Word written to status by the load port |
| result | output | 16 | Registered sum of the last accepted addition |
| resValid | output | 1 | Pulse one cycle after an accepted addition |
| status | output | 16 | Status register |

## Verification
The assertions are evaluated on every cycle. They cover the registered sum, the carry, zero and negative flags against the operands and the result, the valid pulse, the preservation of the unmasked bits, and the hold of all state while the block is idle. Only the bench scenarios can show three things. The first is the flag values at the boundary operands, such as wrap to zero, signed overflow in each direction, and a nibble carry with no word carry. The second is that a load followed by an addition keeps the loaded upper bits. The third is the priority order when a load and an addition coincide.

// File: rtl/flag_adder_pkg.sv
package flag_adder_pkg;
  // Status bit positions written by an addition
  localparam int C_POS  = 0;
  localparam int Z_POS  = 1;
  localparam int OV_POS = 2;
  localparam int N_POS  = 3;
  localparam int DC_POS = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeFlags;
    logic takeLoad;
    logic takeResult;
  } addStrobe_t;

  function automatic logic [31:0] flagMask(input int statW);
    logic [31:0] m;
    m = '0;
    m[C_POS]  = 1'b1;
    m[Z_POS]  = 1'b1;
    m[OV_POS] = 1'b1;
    m[N_POS]  = 1'b1;
    m[DC_POS] = 1'b1;
    if (statW < 32) m = m & ((32'd1 << statW) - 32'd1);
    return m;
  endfunction
endpackage

// File: rtl/flag_adder_flags.sv
module flag_adder_flags
  import flag_adder_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] sumLow,
  output logic [STAT_W-1:0] flagVec
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   wideSum;
  logic [DATA_W-1:0] carryIn;
  logic              fZero, fCarry, fDigit, fOvf, fNeg;

  always_comb begin
    wideSum = {1'b0, opA} + {1'b0, opB};
    sumLow  = wideSum[DATA_W-1:0];
    carryIn = sumLow ^ opA ^ opB;
    fZero   = (sumLow == '0);
    fCarry  = wideSum[DATA_W];
    fDigit  = carryIn[NIB_W];
    fNeg    = sumLow[MSB];
    fOvf    = (~opA[MSB] & ~opB[MSB] &  sumLow[MSB]) |
              ( opA[MSB] &  opB[MSB] & ~sumLow[MSB]);
    flagVec         = '0;
    flagVec[C_POS]  = fCarry;
    flagVec[Z_POS]  = fZero;
    flagVec[OV_POS] = fOvf;
    flagVec[N_POS]  = fNeg;
    flagVec[DC_POS] = fDigit;
  end
endmodule

// File: rtl/flag_adder_dp.sv
module flag_adder_dp
  import flag_adder_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  addStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [STAT_W-1:0] stWrData,
  output logic [DATA_W-1:0] resultQ,
  output logic [STAT_W-1:0] statusQ
);
  localparam logic [31:0]       MASK32    = flagMask(STAT_W);
  localparam logic [STAT_W-1:0] FLAG_MASK = MASK32[STAT_W-1:0];

  logic [DATA_W-1:0] sumLow;
  logic [STAT_W-1:0] flagVec;
  logic [STAT_W-1:0] baseWord;
  logic [STAT_W-1:0] statusNext;

  flag_adder_flags #(.DATA_W(DATA_W), .STAT_W(STAT_W), .NIB_W(NIB_W)) flags_i (
    .opA    (opA),
    .opB    (opB),
    .sumLow (sumLow),
    .flagVec(flagVec)
  );

  assign baseWord = strobe.takeLoad ? stWrData : statusQ;

  for (genvar i = 0; i < STAT_W; i++) begin : gStatBit
    if (FLAG_MASK[i]) begin : gFlag
      assign statusNext[i] = strobe.takeFlags ? flagVec[i] : baseWord[i];
    end else begin : gKeep
      assign statusNext[i] = baseWord[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusQ <= '0;
      resultQ <= '0;
    end else begin
      statusQ <= statusNext;
      if (strobe.takeResult) resultQ <= sumLow;
    end
  end
endmodule

// File: rtl/flag_adder_ctrl.sv
module flag_adder_ctrl
  import flag_adder_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       stWrEn,
  output addStrobe_t strobe,
  output logic       resValidQ
);
  always_comb begin
    strobe.takeFlags  = inValid & ~rst;
    strobe.takeResult = inValid & ~rst;
    strobe.takeLoad   = stWrEn & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) resValidQ <= 1'b0;
    else     resValidQ <= inValid;
  end
endmodule

// File: rtl/flag_adder.sv
module flag_adder
  import flag_adder_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 16,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              inValid,
  input  logic              stWrEn,
  input  logic [STAT_W-1:0] stWrData,
  output logic [DATA_W-1:0] result,
  output logic              resValid,
  output logic [STAT_W-1:0] status
);
  addStrobe_t strobe;

  flag_adder_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .stWrEn   (stWrEn),
    .strobe   (strobe),
    .resValidQ(resValid)
  );

  flag_adder_dp #(.DATA_W(DATA_W), .STAT_W(STAT_W), .NIB_W(NIB_W)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .stWrData(stWrData),
    .resultQ (result),
    .statusQ (status)
  );
endmodule

// File: rtl/flag_adder_chk.sv
module flag_adder_chk
  import flag_adder_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              inValid,
  input logic              stWrEn,
  input logic [STAT_W-1:0] stWrData,
  input logic [DATA_W-1:0] result,
  input logic              resValid,
  input logic [STAT_W-1:0] status
);
  localparam logic [31:0]       MASK32    = flagMask(STAT_W);
  localparam logic [STAT_W-1:0] KEEP_MASK = ~MASK32[STAT_W-1:0];

  logic [DATA_W:0] refSum;
  assign refSum = {1'b0, opA} + {1'b0, opB};

  AST_SUM_REG: assert property (@(posedge clk) disable iff (rst)
    inValid |=> result == $past(refSum[DATA_W-1:0])); // R1
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    inValid |=> resValid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !resValid); // R2
  AST_CARRY_FLAG: assert property (@(posedge clk) disable iff (rst)
    inValid |=> status[C_POS] == $past(refSum[DATA_W])); // R3
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    inValid |=> status[Z_POS] == (result == '0)); // R4
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
    inValid |=> status[N_POS] == result[DATA_W-1]); // R6
  AST_KEEP_BITS: assert property (@(posedge clk) disable iff (rst)
    (inValid && !stWrEn) |=> (status & KEEP_MASK) == ($past(status) & KEEP_MASK)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!inValid && !stWrEn) |=> ($stable(status) && $stable(result))); // R9
  AST_LOAD_BITS: assert property (@(posedge clk) disable iff (rst)
    stWrEn |=> (status & KEEP_MASK) == ($past(stWrData) & KEEP_MASK)); // R10
endmodule

bind flag_adder flag_adder_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) chk_i (
  .clk(clk), .rst(rst), .opA(opA), .opB(opB), .inValid(inValid),
  .stWrEn(stWrEn), .stWrData(stWrData), .result(result),
  .resValid(resValid), .status(status)
);

// File: tb/flag_adder_tb_top.sv
module flag_adder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opA = '0, opB = '0, stWrData = '0;
  logic        inValid = 1'b0, stWrEn = 1'b0;
  logic [15:0] result, status;
  logic        resValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  logic [15:0] expStat = '0;
  logic [15:0] expRes  = '0;

  always #4 clk = ~clk;

  flag_adder dut_i (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .inValid(inValid),
    .stWrEn(stWrEn), .stWrData(stWrData), .result(result),
    .resValid(resValid), .status(status)
  );

  function automatic logic [15:0] modelFlags(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    logic [15:0] f;
    s = {1'b0, a} + {1'b0, b};
    f = '0;
    f[0] = s[16];
    f[1] = (s[15:0] == 16'h0);
    f[2] = (!a[15] && !b[15] && s[15]) || (a[15] && b[15] && !s[15]);
    f[3] = s[15];
    f[8] = (s[15:0] ^ a ^ b) >> 4;
    return f;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; checks right after the capturing edge
  task automatic step(input bit doAdd, input logic [15:0] a, input logic [15:0] b,
                      input bit doLoad, input logic [15:0] ld, input string req);
    logic [15:0] base;
    @(negedge clk);
    opA = a; opB = b; inValid = doAdd; stWrEn = doLoad; stWrData = ld;
    base = doLoad ? ld : expStat;
    if (doAdd) begin
      expStat = (base & 16'hFEF0) | modelFlags(a, b);
      expRes  = a + b;
    end else begin
      expStat = base;
    end
    @(posedge clk);
    #1;
    check({req, " status"}, status, expStat);
    check({req, " result"}, result, expRes);
    check({req, " valid"}, {15'd0, resValid}, {15'd0, doAdd});
    @(negedge clk);
    inValid = 1'b0; stWrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset status", status, 16'h0);
    check("R11 reset result", result, 16'h0);
    check("R11 reset valid", {15'd0, resValid}, 16'h0);
    @(negedge clk);
    rst = 1'b0;

    step(1, 16'h0000, 16'h0000, 0, 0, "R4 zero");
    step(1, 16'hFFFF, 16'h0001, 0, 0, "R3 carry wrap");
    step(1, 16'h7FFF, 16'h0001, 0, 0, "R5 pos overflow R6");
    step(1, 16'h8000, 16'h8000, 0, 0, "R5 neg overflow");
    step(1, 16'h000F, 16'h0001, 0, 0, "R7 digit carry");
    step(1, 16'h0008, 16'h0008, 0, 0, "R7 nibble sum");
    step(1, 16'h1234, 16'h4321, 0, 0, "R1 plain sum");
    step(0, 16'hAAAA, 16'h5555, 1, 16'hFFFF, "R10 load");
    step(1, 16'h0001, 16'h0001, 0, 0, "R8 keep upper");
    check("R8 kept bits", status, 16'hFEF0);
    step(0, 16'h9999, 16'h9999, 0, 0, "R9 idle hold");
    step(0, 16'h0000, 16'h0000, 0, 0, "R2 idle valid");
    step(1, 16'h0000, 16'h0000, 1, 16'hAAAA, "R10 load and add");
    check("R10 coincident", status, 16'hAAA2);

    for (int i = 0; i < 300; i++) begin
      logic [15:0] a, b, ld;
      bit ad, lo;
      a  = 16'($urandom);
      b  = 16'($urandom);
      ld = 16'($urandom);
      ad = ($urandom % 4) != 0;
      lo = ($urandom % 6) == 0;
      if (i % 7 == 0) b = -a;
      step(ad, a, b, lo, ld, "R1 R3 R4 R5 R6 R7 random");
    end

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R11 rerun reset", status, 16'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #200000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule